// File: doc/BRIEF.md
# Per-CPU Local Tick Timer Bank

This block holds one local countdown timer for each CPU in a cluster. Each timer has two stages. A tick counter counts down from a programmed tick period and reloads itself every time it passes zero. Every such underflow decrements an interrupt counter. When an underflow finds the interrupt counter already at zero, the timer expires: its status flag is set, and its interrupt line rises if that line is enabled.

Software programs each timer through a register window. The window for CPU n starts at byte address 0x300 + 0x100·n. Each stage has its own start bit. A mode bit chooses what happens at expiry. In interval mode the interrupt counter reloads and the timer keeps running. In one-shot mode both start bits clear and the timer halts. Each write to a period buffer or to the control register raises a sticky acknowledge flag. Software clears these flags by writing 1 to them.

Top module: `ltt_bank`

## Requirements
- R1: After reset every register of every timer reads 0 and every interrupt line is low.
- R2: Register offsets inside a timer's window are: tick period buffer 0x00, interrupt-count buffer 0x08, control 0x20, status 0x30, enable 0x34, write-acknowledge 0x40. Both buffers read back the full 32-bit value written. An address outside the six registers of every window reads 0.
- R3: Control bit 0 runs the tick counter, bit 1 runs the interrupt counter, and bit 2 selects interval mode. A control write that raises bit 0 loads the tick counter from its buffer at that clock edge. A write that raises bit 1 does the same for the interrupt counter.
- R4: A running tick counter with buffer value T underflows every T+1 cycles and reloads from the buffer.
- R5: While bit 1 is set, each tick underflow decrements the interrupt counter. An underflow that finds it at zero is an expiry, which sets status bit 0. The first expiry comes (T+1)·(N+1) cycles after the starting write edge, where N is the interrupt-count buffer value.
- R6: On an expiry with bit 2 clear, control bits 1:0 read back as 0 and no further expiry occurs.
- R7: On an expiry with bit 2 set, the interrupt counter reloads from its buffer. Expiries repeat every (T+1)·(N+1) cycles and the control value is unchanged.
- R8: Clearing bit 0 freezes the tick counter, and the interrupt counter keeps its count. Setting bit 0 again, with bit 1 left set, reloads only the tick counter.
- R9: The interrupt line equals status bit 0 AND enable bit 0. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. With enable at 0, status still sets.
- R10: In the write-acknowledge register, bit 0 sets after a tick buffer write, bit 1 after an interrupt-count buffer write, and bit 3 after a control write. The flags are sticky. Writing 1 clears only the bits that are 1 in the written data.
- R11: A write addressed to one timer changes no other timer, and each timer drives only its own interrupt bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Byte address of the register to write or read |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data of the register at `addr` |
| irq | output | NCPU | Interrupt line of each timer |

## Verification
The hardest state to reach from the ports is a frozen interrupt counter holding a partial count. The counters cannot be read back, so this state shows only in the timing of the next expiry. The stimulus starts a timer, stops only the tick stage partway between two underflows, idles, and then restarts the tick stage. The expiry must then arrive after (T+1) times the remaining count plus one, not after the full product. Interval repetition is checked the same way: the status is cleared between expiries and the second one must land exactly one period after the first.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
  // Register offsets within one timer window (software decodes these)
  localparam logic [7:0] OFF_TBUF = 8'h00;
  localparam logic [7:0] OFF_IBUF = 8'h08;
  localparam logic [7:0] OFF_CTRL = 8'h20;
  localparam logic [7:0] OFF_STAT = 8'h30;
  localparam logic [7:0] OFF_EN   = 8'h34;
  localparam logic [7:0] OFF_WACK = 8'h40;

  // Control bit positions
  localparam int B_TRUN = 0;
  localparam int B_IRUN = 1;
  localparam int B_IVAL = 2;

  // Write-acknowledge bit positions
  localparam int WA_TBUF = 0;
  localparam int WA_IBUF = 1;
  localparam int WA_CTRL = 3;

  // First window sits at page 0x3 (0x300), one page per CPU
  localparam int BASE_PAGE = 3;

  function automatic int win_base(input int cpu);
    return (BASE_PAGE + cpu) * 256;
  endfunction

  // Cycles from the starting write edge to the first expiry
  function automatic longint expiry_cycles(input longint t, input longint n);
    return (t + 1) * (n + 1);
  endfunction
endpackage

// File: rtl/ltt_counter.sv
module ltt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ltt_channel.sv
module ltt_channel
  import ltt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       reg_off,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  logic [CNT_W-1:0] tbuf_q, ibuf_q;
  logic [2:0]       ctrl_q;
  logic             stat_q, en_q;
  logic             wa_tb_q, wa_ib_q, wa_ct_q;

  // Named internal events
  logic wr_tb, wr_ib, wr_ct, wr_st, wr_en_r, wr_wa;
  logic tick_rise, icnt_rise, tick_uf, expire;
  logic t_zero, i_zero;
  logic [CNT_W-1:0] tcnt, icnt;

  assign wr_tb   = we && (reg_off == OFF_TBUF);
  assign wr_ib   = we && (reg_off == OFF_IBUF);
  assign wr_ct   = we && (reg_off == OFF_CTRL);
  assign wr_st   = we && (reg_off == OFF_STAT);
  assign wr_en_r = we && (reg_off == OFF_EN);
  assign wr_wa   = we && (reg_off == OFF_WACK);

  assign tick_rise = wr_ct && wdata[B_TRUN] && !ctrl_q[B_TRUN];
  assign icnt_rise = wr_ct && wdata[B_IRUN] && !ctrl_q[B_IRUN];
  assign tick_uf   = ctrl_q[B_TRUN] && t_zero;
  assign expire    = tick_uf && ctrl_q[B_IRUN] && i_zero;

  ltt_counter #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .load(tick_rise || tick_uf), .load_val(tbuf_q),
    .step(ctrl_q[B_TRUN]),
    .cnt_o(tcnt), .zero_o(t_zero)
  );

  ltt_counter #(.CNT_W(CNT_W)) u_icnt (
    .clk(clk), .rst_n(rst_n),
    .load(icnt_rise || (expire && ctrl_q[B_IVAL])), .load_val(ibuf_q),
    .step(tick_uf && ctrl_q[B_IRUN] && !i_zero),
    .cnt_o(icnt), .zero_o(i_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf_q  <= '0;
      ibuf_q  <= '0;
      ctrl_q  <= '0;
      stat_q  <= 1'b0;
      en_q    <= 1'b0;
      wa_tb_q <= 1'b0;
      wa_ib_q <= 1'b0;
      wa_ct_q <= 1'b0;
    end else begin
      if (wr_tb) tbuf_q <= wdata;
      if (wr_ib) ibuf_q <= wdata;
      if (wr_en_r) en_q <= wdata[0];
      if (wr_ct) ctrl_q <= wdata[2:0];
      else if (expire && !ctrl_q[B_IVAL]) begin
        ctrl_q[B_TRUN] <= 1'b0;
        ctrl_q[B_IRUN] <= 1'b0;
      end
      if (expire) stat_q <= 1'b1;
      else if (wr_st && wdata[0]) stat_q <= 1'b0;
      if (wr_tb) wa_tb_q <= 1'b1;
      else if (wr_wa && wdata[WA_TBUF]) wa_tb_q <= 1'b0;
      if (wr_ib) wa_ib_q <= 1'b1;
      else if (wr_wa && wdata[WA_IBUF]) wa_ib_q <= 1'b0;
      if (wr_ct) wa_ct_q <= 1'b1;
      else if (wr_wa && wdata[WA_CTRL]) wa_ct_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_off)
      OFF_TBUF: rdata = tbuf_q;
      OFF_IBUF: rdata = ibuf_q;
      OFF_CTRL: rdata[2:0] = ctrl_q;
      OFF_STAT: rdata[0] = stat_q;
      OFF_EN:   rdata[0] = en_q;
      OFF_WACK: begin
        rdata[WA_TBUF] = wa_tb_q;
        rdata[WA_IBUF] = wa_ib_q;
        rdata[WA_CTRL] = wa_ct_q;
      end
      default: rdata = '0;
    endcase
  end

  assign irq = stat_q && en_q;

  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick_uf |=> tcnt == $past(tbuf_q)); // R4
  AST_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_TRUN] && !tick_rise) |=> $stable(tcnt)); // R8
  AST_ICNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_IRUN] && !icnt_rise) |=> $stable(icnt)); // R8
  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q); // R5
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q[B_IVAL] && !wr_ct) |=> (ctrl_q[1:0] == 2'b00)); // R6
  AST_IVAL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q[B_IVAL]) |=> icnt == $past(ibuf_q)); // R7
  AST_WACK_TBUF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tb |=> wa_tb_q); // R10
endmodule

// File: rtl/ltt_bank.sv
module ltt_bank
  import ltt_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NCPU-1:0]   irq
);
  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  logic [CNT_W-1:0]  rd_ch [NCPU];
  logic [NCPU-1:0]   hit;

  assign page = addr[ADDR_W-1:8];

  for (genvar n = 0; n < NCPU; n++) begin : g_ch
    assign hit[n] = (int'(page) == BASE_PAGE + n);

    ltt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && hit[n]),
      .reg_off(addr[7:0]),
      .wdata(wdata),
      .rdata(rd_ch[n]),
      .irq(irq[n])
    );
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NCPU; n++)
      if (hit[n]) rdata = rd_ch[n];
  end

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R11
endmodule

// File: tb/test_ltt_bank.sv
module test_ltt_bank;
  import ltt_pkg::*;

  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [NCPU-1:0] irq;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  ltt_bank #(.NCPU(NCPU), .ADDR_W(12), .CNT_W(32)) i_ltt_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // cpu, tick buffer T, interrupt-count buffer N, interval
  localparam int VEC [0:5][0:3] = '{
    '{0, 0, 0, 0}, '{1, 2, 1, 0}, '{2, 4, 2, 1},
    '{3, 1, 5, 1}, '{0, 7, 0, 1}, '{2, 0, 3, 0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ra(input int c, input int off);
    return 'h300 + 'h100 * c + off;
  endfunction

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(input int a, input logic [31:0] d);
    addr = a[11:0]; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = a[11:0]; #1; d = rdata;
  endtask

  task automatic wait_irq(input int c, input int base, output int dt);
    int k = 0;
    while (!irq[c] && k < 20000) begin @(negedge clk); k++; end
    dt = cyc - base;
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0, dt, p, c;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {28'b0, irq}, 32'h0);
    for (int k = 0; k < NCPU; k++) begin
      rd(ra(k, 'h00), d); chk("R1 tbuf", d, 0);
      rd(ra(k, 'h20), d); chk("R1 ctrl", d, 0);
      rd(ra(k, 'h40), d); chk("R1 wack", d, 0);
    end

    // R2 map and readback, R10 acknowledge flags, R11 isolation
    wr(ra(2, 'h00), 32'hDEADBEEF);
    rd(ra(2, 'h00), d); chk("R2 tbuf readback", d, 32'hDEADBEEF);
    rd(ra(2, 'h40), d); chk("R10 wack tbuf", d, 32'h1);
    wr(ra(2, 'h08), 32'h89ABCDEF);
    rd(ra(2, 'h08), d); chk("R2 ibuf readback", d, 32'h89ABCDEF);
    rd(ra(2, 'h40), d); chk("R10 wack ibuf", d, 32'h3);
    wr(ra(2, 'h20), 32'h0);
    rd(ra(2, 'h40), d); chk("R10 wack ctrl", d, 32'hB);
    wr(ra(2, 'h40), 32'h2);
    rd(ra(2, 'h40), d); chk("R10 w1c partial", d, 32'h9);
    wr(ra(2, 'h40), 32'hB);
    rd(ra(2, 'h40), d); chk("R10 w1c all", d, 32'h0);
    rd(ra(1, 'h00), d); chk("R11 other tbuf", d, 0);
    rd(ra(3, 'h40), d); chk("R11 other wack", d, 0);
    rd(ra(2, 'h04), d); chk("R2 hole", d, 0);
    rd('h010, d); chk("R2 below window", d, 0);

    // Table-driven expiry: R3 R4 R5 R6 R7 R11
    for (int v = 0; v < 6; v++) begin
      c = VEC[v][0];
      p = int'(expiry_cycles(VEC[v][1], VEC[v][2]));
      wr(ra(c, 'h00), VEC[v][1]);
      wr(ra(c, 'h08), VEC[v][2]);
      wr(ra(c, 'h34), 32'h1);
      wr(ra(c, 'h20), VEC[v][3] ? 32'h7 : 32'h3);
      c0 = cyc;
      chk("R5 no early irq", {31'b0, irq[c]}, 0);
      wait_irq(c, c0, dt);
      chk("R5 first expiry cycle", dt, p);
      chk("R11 other irqs low", {28'b0, irq & ~(4'b1 << c)}, 0);
      rd(ra(c, 'h30), d); chk("R5 status set", d, 1);
      if (VEC[v][3] != 0) begin
        rd(ra(c, 'h20), d); chk("R7 ctrl kept", d, 7);
        wr(ra(c, 'h30), 32'h1);
        chk("R9 cleared irq", {31'b0, irq[c]}, 0);
        wait_irq(c, c0, dt);
        chk("R7 second expiry cycle", dt, 2 * p);
        wr(ra(c, 'h20), 32'h0);
        wr(ra(c, 'h30), 32'h1);
      end else begin
        rd(ra(c, 'h20), d); chk("R6 ctrl halted", d, 0);
        wr(ra(c, 'h30), 32'h1);
        repeat (3 * p + 5) @(negedge clk);
        chk("R6 no second expiry", {31'b0, irq[c]}, 0);
      end
    end

    // R8 freeze: T=3 N=3, stop tick stage after one underflow
    wr(ra(1, 'h00), 3);
    wr(ra(1, 'h08), 3);
    wr(ra(1, 'h20), 32'h3);
    c0 = cyc;
    while (cyc - c0 < 5) @(negedge clk);
    wr(ra(1, 'h20), 32'h2);
    repeat (30) @(negedge clk);
    chk("R8 frozen no irq", {31'b0, irq[1]}, 0);
    wr(ra(1, 'h20), 32'h3);
    c0 = cyc;
    wait_irq(1, c0, dt);
    chk("R8 resumed expiry uses held count", dt, 12);
    wr(ra(1, 'h30), 32'h1);

    // R9 enable gating and W1C
    wr(ra(3, 'h34), 32'h0);
    wr(ra(3, 'h00), 1);
    wr(ra(3, 'h08), 0);
    wr(ra(3, 'h20), 32'h3);
    repeat (10) @(negedge clk);
    chk("R9 masked irq", {31'b0, irq[3]}, 0);
    rd(ra(3, 'h30), d); chk("R9 status while masked", d, 1);
    wr(ra(3, 'h30), 32'h0);
    rd(ra(3, 'h30), d); chk("R9 write 0 ignored", d, 1);
    wr(ra(3, 'h34), 32'h1);
    chk("R9 unmask irq", {31'b0, irq[3]}, 1);
    wr(ra(3, 'h30), 32'h1);
    rd(ra(3, 'h30), d); chk("R9 w1c status", d, 0);
    chk("R9 irq after clear", {31'b0, irq[3]}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule